// File: doc/BRIEF.md
# Serial Register Port with Deferred Commit

This block is the configuration port of a frequency-synthesizer core. A host reaches it over a four-wire serial link with an active-low select, a serial clock, a data input and a data output. Every frame opens with one instruction byte, which names a register and gives the direction of the transfer. A fixed number of data bytes follows, and that number depends on the register. The block oversamples all of the serial pins with its own system clock. It therefore needs a system clock several times faster than the serial clock.

A write does not change the register the core sees. A complete write frame places its value in a shadow copy and marks that copy pending. On the next rising edge of a separate update strobe, every pending shadow value moves into the active registers at once, so the core sees several related settings change together. A read always returns the active value. An I/O reset input drops any half-finished transfer. The control register, which is the four-byte register, holds two bits that steer the port itself: the bit order on the wire and whether the data-output driver is enabled.

Top module: `dds_spi_port`

## Requirements
- R1: In the instruction byte, bit 7 = 1 selects a read and 0 a write, bits 3:0 give the address, and bits 6:4 are ignored.
- R2: The data length is 2 bytes at addresses 0, 1, 8 and 9, 6 bytes at 2 and 3, and 4 bytes at 7. The first data byte on the wire is the most significant byte of the register value.
- R3: A completed write changes only the shadow copy. The active outputs hold their values until the update strobe rises, and that edge commits every pending register together.
- R4: A write frame whose select rises before all of its data bytes have arrived leaves both the shadow copy and the active registers unchanged.
- R5: While io_reset is high, the partial transfer is dropped. The next byte clocked within the same select-low period is taken as a new instruction.
- R6: A read returns the active value, even while a different shadow value is pending.
- R7: Addresses outside {0,1,2,3,7,8,9} read as zero bytes. Writes to them have no effect on any output.
- R8: Control bit 1 (ctrl_o[1]) selects the bit order of every byte, instruction included. 0 sends bit 7 first and 1 sends bit 0 first.
- R9: sdo_oe is high only in the data phase of a read frame while the select is low and control bit 0 (ctrl_o[0]) is 1. Otherwise sdo_oe is low.
- R10: sdi is sampled on the rising edge of sclk (mode 0). sdo changes only after a falling edge of sclk, so it is stable across each rising edge.
- R11: After reset, every active register is zero except the control register, which is 0x00000001 (MSB first, output enabled), and sdo_oe is low.
- R12: In a write, data bytes beyond the register length are ignored. In a read, bytes beyond the length come out as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| io_reset | input | 1 | Level that aborts the current transfer |
| upd_strobe | input | 1 | Rising edge commits the pending shadow values |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| phase0_o | output | 16 | Active register at address 0 |
| phase1_o | output | 16 | Active register at address 1 |
| tuning0_o | output | 48 | Active register at address 2 |
| tuning1_o | output | 48 | Active register at address 3 |
| ctrl_o | output | 32 | Active control register at address 7 |
| ampl_i_o | output | 16 | Active register at address 8 |
| ampl_q_o | output | 16 | Active register at address 9 |

## Verification
The bench writes a value and reads it back before the strobe. A design that committed at once would return the new value instead of zero. It cuts a frame one byte short, and a design that streamed bytes straight into the shadow copy would commit a half-written register. It pulses io_reset mid-frame and then sends a fresh instruction under the same select. A design that ignored the reset would take that instruction as a data byte and commit a wrong value. It also switches to LSB-first order with the output disabled. There a wrong bit order shows up as scrambled control values, and an output enable that leaks shows sdo_oe high.

// File: rtl/dds_spi_pkg.sv
package dds_spi_pkg;

    localparam int ADDR_W    = 4;
    localparam int MAX_BYTES = 6;
    localparam int VAL_W     = 8 * MAX_BYTES;
    localparam int NREG      = 10;
    localparam int CTRL_ADDR = 7;
    localparam int BIT_SDO_EN = 0;
    localparam int BIT_LSB    = 1;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // byte count per address, zero means not present
    function automatic logic [2:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            4'd0, 4'd1, 4'd8, 4'd9: reg_len = 3'd2;
            4'd2, 4'd3:             reg_len = 3'd6;
            4'd7:                   reg_len = 3'd4;
            default:                reg_len = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dds_spi_sync.sv
module dds_spi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d_i;
        s_d.s2 = s_q.s1;
        s_d.s3 = s_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= {RST_VAL, RST_VAL, RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.s2;
    assign rise_o = s_q.s2 & ~s_q.s3;
    assign fall_o = ~s_q.s2 & s_q.s3;

endmodule

// File: rtl/dds_spi_engine.sv
module dds_spi_engine
    import dds_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi,
    input  logic              iorst,
    input  logic              lsb_first,
    input  logic              sdo_en,
    input  logic [VAL_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [VAL_W-1:0]  wr_data,
    output logic              sdo,
    output logic              sdo_oe
);

    typedef struct packed {
        phase_e             phase;
        logic [2:0]         bit_cnt;
        logic [2:0]         byte_cnt;
        logic [7:0]         shreg;
        logic [ADDR_W-1:0]  addr;
        logic [VAL_W-1:0]   stage;
        logic               wr_valid;
        logic               sdo;
    } eng_t;

    eng_t s_d, s_q;

    logic [7:0] nb;
    logic [2:0] cur_len;
    logic [2:0] ridx;
    logic [2:0] bsel;
    logic       rd_bit;

    always_comb begin
        s_d          = s_q;
        s_d.wr_valid = 1'b0;
        nb      = lsb_first ? {sdi, s_q.shreg[7:1]} : {s_q.shreg[6:0], sdi};
        cur_len = reg_len(s_q.addr);
        ridx    = cur_len - 3'd1 - s_q.byte_cnt;
        bsel    = lsb_first ? s_q.bit_cnt : (3'd7 - s_q.bit_cnt);
        rd_bit  = (s_q.byte_cnt < cur_len) ? rd_data[{ridx, bsel}] : 1'b0;

        if (!cs_act || iorst) begin
            s_d.phase    = PH_INSTR;
            s_d.bit_cnt  = '0;
            s_d.byte_cnt = '0;
            s_d.shreg    = '0;
        end else begin
            if (sclk_rise) begin
                s_d.shreg   = nb;
                s_d.bit_cnt = s_q.bit_cnt + 3'd1;
                if (s_q.bit_cnt == 3'd7) begin
                    case (s_q.phase)
                        PH_INSTR: begin
                            s_d.addr     = nb[ADDR_W-1:0];
                            s_d.byte_cnt = '0;
                            s_d.stage    = '0;
                            if (nb[7]) begin
                                s_d.phase = PH_RDATA;
                            end else if (reg_len(nb[ADDR_W-1:0]) == 3'd0) begin
                                s_d.phase = PH_DONE;
                            end else begin
                                s_d.phase = PH_WDATA;
                            end
                        end
                        PH_WDATA: begin
                            s_d.stage    = {s_q.stage[VAL_W-9:0], nb};
                            s_d.byte_cnt = s_q.byte_cnt + 3'd1;
                            if (s_q.byte_cnt + 3'd1 == cur_len) begin
                                s_d.wr_valid = 1'b1;
                                s_d.phase    = PH_DONE;
                            end
                        end
                        PH_RDATA: begin
                            if (s_q.byte_cnt != 3'd7) begin
                                s_d.byte_cnt = s_q.byte_cnt + 3'd1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && s_q.phase == PH_RDATA) begin
                s_d.sdo = rd_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_INSTR;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_addr  = s_q.addr;
    assign wr_addr  = s_q.addr;
    assign wr_data  = s_q.stage;
    assign wr_valid = s_q.wr_valid;
    assign sdo      = s_q.sdo;
    assign sdo_oe   = sdo_en && cs_act && (s_q.phase == PH_RDATA);

    // abort returns the engine to instruction capture
    p_iorst_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iorst |=> (s_q.phase == PH_INSTR && s_q.bit_cnt == 3'd0));

    // only listed addresses ever reach the shadow port
    p_wr_listed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_valid |-> (reg_len(s_q.addr) != 3'd0));

    // output bit moves only after a falling serial edge
    p_sdo_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(s_q.sdo));

endmodule

// File: rtl/dds_spi_bank.sv
module dds_spi_bank
    import dds_spi_pkg::*;
#(
    parameter logic [31:0] CTRL_RST = 32'h0000_0001
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [VAL_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [VAL_W-1:0]            rd_data,
    output logic [NREG-1:0][VAL_W-1:0]  active_o
);

    typedef struct packed {
        logic [NREG-1:0][VAL_W-1:0] shadow;
        logic [NREG-1:0][VAL_W-1:0] active;
        logic [NREG-1:0]            pend;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (commit) begin
            for (int i = 0; i < NREG; i++) begin
                if (s_q.pend[i]) begin
                    s_d.active[i] = s_q.shadow[i];
                end
            end
            s_d.pend = '0;
        end
        if (wr_valid && reg_len(wr_addr) != 3'd0) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    s_d.shadow[i] = wr_data;
                    s_d.pend[i]   = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = s_q.active[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q                   <= '0;
            s_q.active[CTRL_ADDR] <= VAL_W'(CTRL_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;

    // active values only move on a commit
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(s_q.active));

    // a pending control value lands on commit
    p_commit_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && s_q.pend[CTRL_ADDR]) |=>
            (s_q.active[CTRL_ADDR] == $past(s_q.shadow[CTRL_ADDR])));

endmodule

// File: rtl/dds_spi_port.sv
module dds_spi_port
    import dds_spi_pkg::*;
#(
    parameter logic [31:0] CTRL_RST = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        sdi,
    input  logic        io_reset,
    input  logic        upd_strobe,
    output logic        sdo,
    output logic        sdo_oe,
    output logic [15:0] phase0_o,
    output logic [15:0] phase1_o,
    output logic [47:0] tuning0_o,
    output logic [47:0] tuning1_o,
    output logic [31:0] ctrl_o,
    output logic [15:0] ampl_i_o,
    output logic [15:0] ampl_q_o
);

    localparam int SYNC_W = 5;
    localparam int I_SCLK = 0;
    localparam int I_CS   = 1;
    localparam int I_SDI  = 2;
    localparam int I_IOR  = 3;
    localparam int I_UPD  = 4;

    logic [SYNC_W-1:0] lvl, rise, fall;
    logic [NREG-1:0][VAL_W-1:0] act;
    logic [VAL_W-1:0]  rd_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [VAL_W-1:0]  wr_data;
    logic              wr_valid;

    dds_spi_sync #(
        .W       (SYNC_W),
        .RST_VAL (5'b00010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({upd_strobe, io_reset, sdi, cs_n, sclk}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    dds_spi_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (rise[I_SCLK]),
        .sclk_fall (fall[I_SCLK]),
        .cs_act    (!lvl[I_CS]),
        .sdi       (lvl[I_SDI]),
        .iorst     (lvl[I_IOR]),
        .lsb_first (act[CTRL_ADDR][BIT_LSB]),
        .sdo_en    (act[CTRL_ADDR][BIT_SDO_EN]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    dds_spi_bank #(
        .CTRL_RST (CTRL_RST)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (rise[I_UPD]),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .active_o (act)
    );

    assign phase0_o  = act[0][15:0];
    assign phase1_o  = act[1][15:0];
    assign tuning0_o = act[2];
    assign tuning1_o = act[3];
    assign ctrl_o    = act[CTRL_ADDR][31:0];
    assign ampl_i_o  = act[8][15:0];
    assign ampl_q_o  = act[9][15:0];

    logic unused_bits;
    assign unused_bits = ^{lvl[I_SCLK], lvl[I_UPD], rise[I_CS], rise[I_SDI], rise[I_IOR],
                           fall[I_CS], fall[I_SDI], fall[I_IOR], fall[I_UPD],
                           act[6], act[5], act[4], act[0][47:16], act[1][47:16],
                           act[CTRL_ADDR][47:32], act[8][47:16], act[9][47:16]};

    // driver enable never on while the control register disables it
    p_oe_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> ctrl_o[BIT_SDO_EN]);

    // no driver while the frame select is high (after synchronizer delay)
    p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

endmodule

// File: tb/dds_spi_port_tb.sv
module dds_spi_port_tb;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, io_reset = 1'b0, upd_strobe = 1'b0;
    logic sdo, sdo_oe;
    logic [15:0] phase0_o, phase1_o, ampl_i_o, ampl_q_o;
    logic [47:0] tuning0_o, tuning1_o;
    logic [31:0] ctrl_o;

    always #2.5 clk = ~clk;

    dds_spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .io_reset(io_reset), .upd_strobe(upd_strobe), .sdo(sdo), .sdo_oe(sdo_oe),
        .phase0_o(phase0_o), .phase1_o(phase1_o), .tuning0_o(tuning0_o),
        .tuning1_o(tuning1_o), .ctrl_o(ctrl_o), .ampl_i_o(ampl_i_o), .ampl_q_o(ampl_q_o)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [47:0] act_m [10];
    logic [47:0] shd_m [10];
    bit          pend_m [10];

    logic [8:0] exp_q [$];
    logic [8:0] got_q [$];
    string      req_q [$];

    function automatic int blen(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd8, 4'd9: return 2;
            4'd2, 4'd3:             return 6;
            4'd7:                   return 4;
            default:                return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic chk_outs(input string req);
        chk(phase0_o  == act_m[0][15:0], req, 64'(phase0_o),  64'(act_m[0][15:0]));
        chk(phase1_o  == act_m[1][15:0], req, 64'(phase1_o),  64'(act_m[1][15:0]));
        chk(tuning0_o == act_m[2],       req, 64'(tuning0_o), 64'(act_m[2]));
        chk(tuning1_o == act_m[3],       req, 64'(tuning1_o), 64'(act_m[3]));
        chk(ctrl_o    == act_m[7][31:0], req, 64'(ctrl_o),    64'(act_m[7][31:0]));
        chk(ampl_i_o  == act_m[8][15:0], req, 64'(ampl_i_o),  64'(act_m[8][15:0]));
        chk(ampl_q_o  == act_m[9][15:0], req, 64'(ampl_q_o),  64'(act_m[9][15:0]));
    endtask

    // monitor: compares each received read byte against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [8:0] g, e;
                string r;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(g == e, r, 64'(g), 64'(e));
            end
        end
    end

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         output bit oe_any, output bit stable_ok);
        rx = '0;
        oe_any = 1'b0;
        stable_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int k;
            logic b;
            k = act_m[7][1] ? i : 7 - i;
            sdi = tx[k];
            repeat (HALF) @(negedge clk);
            rx[k] = sdo;
            b = sdo;
            if (sdo_oe) oe_any = 1'b1;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (sdo_oe && sdo !== b) stable_ok = 1'b0;
            sclk = 1'b0;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] instr, input logic [47:0] val, input int nsend);
        logic [3:0] a;
        int L;
        logic [7:0] r;
        bit o, s;
        a = instr[3:0];
        L = blen(a);
        frame_start();
        xbyte(instr, r, o, s);
        for (int j = 0; j < nsend; j++) begin
            xbyte((j < L) ? val[8*(L-1-j) +: 8] : 8'hEE, r, o, s);
        end
        frame_end();
        if (L > 0 && nsend >= L) begin
            shd_m[a]  = val & ((48'h1 << (8 * L)) - 48'h1);
            pend_m[a] = 1'b1;
        end
    endtask

    task automatic rd(input logic [7:0] instr, input int nb, input string req);
        logic [3:0] a;
        int L;
        bit en, stab;
        logic [7:0] r;
        bit o, s;
        a = instr[3:0];
        L = blen(a);
        en = act_m[7][0];
        for (int j = 0; j < nb; j++) begin
            logic [7:0] e;
            e = (j < L) ? act_m[a][8*(L-1-j) +: 8] : 8'h00;
            exp_q.push_back({en, en ? e : 8'h00});
            req_q.push_back(req);
        end
        frame_start();
        xbyte(instr, r, o, s);
        stab = 1'b1;
        for (int j = 0; j < nb; j++) begin
            xbyte(8'h00, r, o, s);
            got_q.push_back({o, o ? r : 8'h00});
            stab = stab & s;
        end
        frame_end();
        chk(stab, "R10", 64'(stab), 64'd1);
    endtask

    task automatic upd();
        upd_strobe = 1'b1;
        repeat (4) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (pend_m[i]) act_m[i] = shd_m[i];
            pend_m[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) begin
            act_m[i] = '0;
            shd_m[i] = '0;
            pend_m[i] = 1'b0;
        end
        act_m[7] = 48'h1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk_outs("R11");
        chk(sdo_oe == 1'b0, "R11", 64'(sdo_oe), 64'd0);

        // R3 / R6: write lands in shadow only, read still sees active
        wr(8'h00, 48'h1234, 2);
        chk(phase0_o == 16'h0000, "R3", 64'(phase0_o), 64'h0);
        rd(8'h80, 2, "R6");
        upd();
        chk_outs("R3");
        rd(8'h80, 2, "R2");

        // R2 / R3: several registers, one commit
        wr(8'h02, 48'hA1B2C3D4E5F6, 6);
        wr(8'h03, 48'h0123456789AB, 6);
        wr(8'h08, 48'h0FC0, 2);
        wr(8'h09, 48'h0ABC, 2);
        chk(tuning0_o == 48'h0, "R3", 64'(tuning0_o), 64'h0);
        upd();
        chk_outs("R2");
        rd(8'h82, 6, "R2");
        rd(8'h89, 2, "R2");

        // R1: upper instruction bits ignored
        wr(8'h71, 48'h2000, 2);
        upd();
        chk(phase1_o == 16'h2000, "R1", 64'(phase1_o), 64'h2000);
        rd(8'hF1, 2, "R1");

        // R4: short frame commits nothing
        wr(8'h08, 48'h7777, 1);
        upd();
        chk(ampl_i_o == 16'h0FC0, "R4", 64'(ampl_i_o), 64'h0FC0);

        // R5: abort mid-frame, new instruction in same select period
        begin
            logic [7:0] r;
            bit o, s;
            frame_start();
            xbyte(8'h09, r, o, s);
            xbyte(8'h11, r, o, s);
            io_reset = 1'b1;
            repeat (4) @(negedge clk);
            io_reset = 1'b0;
            repeat (4) @(negedge clk);
            xbyte(8'h09, r, o, s);
            xbyte(8'hBE, r, o, s);
            xbyte(8'hEF, r, o, s);
            frame_end();
            shd_m[9] = 48'hBEEF;
            pend_m[9] = 1'b1;
        end
        upd();
        chk(ampl_q_o == 16'hBEEF, "R5", 64'(ampl_q_o), 64'hBEEF);

        // R7: unlisted address
        wr(8'h05, 48'h5A5A, 2);
        upd();
        chk_outs("R7");
        rd(8'h85, 2, "R7");

        // R12: surplus bytes on write, zeros past length on read
        wr(8'h00, 48'hCAFE, 4);
        upd();
        chk(phase0_o == 16'hCAFE, "R12", 64'(phase0_o), 64'hCAFE);
        rd(8'h80, 4, "R12");

        // R9 / R8: LSB first with the output disabled
        wr(8'h07, 48'h00000002, 4);
        upd();
        chk(ctrl_o == 32'h2, "R8", 64'(ctrl_o), 64'h2);
        rd(8'h80, 2, "R9");
        // re-enable output, frame sent bit 0 first
        wr(8'h07, 48'h00000003, 4);
        upd();
        chk(ctrl_o == 32'h3, "R8", 64'(ctrl_o), 64'h3);
        wr(8'h01, 48'h8421, 2);
        upd();
        chk(phase1_o == 16'h8421, "R8", 64'(phase1_o), 64'h8421);
        rd(8'h81, 2, "R8");
        rd(8'h83, 6, "R9");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule